// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

A countdown watchdog programmed through a small byte-wide register port. Software loads a 16-bit count, split across a low byte and a high byte register, and picks the unit with one configuration bit: each pulse of a free-running one-second tick input decrements the count, or every sixtieth pulse does so when the minute unit is selected. A nonzero count means the timer is armed. Writing zero into both count bytes stops it.

When the count runs out, the block raises one-cycle pulses on a keyboard-reset request output, on a power-OK reset output and on a timeout-event output. Each of these pulses has its own enable bit in the configuration register. After the pulses the count is zero, so the timer has stopped. Software keeps the timer from expiring by rewriting a count byte, which also restarts the minute prescaler. The low four configuration bits and the control register are plain storage that software can read back. A parameter selects a legacy variant that keeps only the low count byte.

Top module: `unit_watchdog`

## Requirements
- R1: After reset, every register reads 0x00. `running` is low and all three expiry outputs are low.
- R2: A write stores `wrData` in the register selected by `addr`: 0x71 control, 0x72 configuration, 0x73 count low byte, 0x74 count high byte. Reading any of these four addresses returns the stored value combinationally. Any other address reads 0x00, and a write to it changes no register.
- R3: `running` is high exactly when the count (high byte, low byte) is nonzero. Writing zero into both count bytes stops the timer, and a stopped timer never decrements and never expires.
- R4: With configuration bit 7 set (seconds unit), every clock cycle that has `tick` high, no write and a nonzero count decrements the count by one.
- R5: With configuration bit 7 clear (minutes unit), the count decrements on every 60th qualifying tick, counted from the last count write. The first decrement falls on the 60th tick after that write. Cycles without `tick` change nothing.
- R6: On the edge where the count steps from 1 to 0, each output is set for exactly the next cycle according to its enable: `kbdRst` by configuration bit 6, `toEvent` by bit 5 and `pwrOkRst` by bit 4. During such a pulse, `running` is low.
- R7: Writing a count byte reloads that byte at once and clears the minute prescaler. Any write in a cycle overrides that cycle's tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| tick | input | 1 | One-cycle pulse per second |
| running | output | 1 | Count is nonzero |
| kbdRst | output | 1 | Keyboard-reset request pulse |
| pwrOkRst | output | 1 | Power-OK reset pulse |
| toEvent | output | 1 | Timeout event pulse |

## Verification
The bench goes after the minute prescaler boundary: a design off by one there expires a tick early or late, and the pulse check catches that cycle. It drives a write and a tick in the same cycle; a design that lets the tick win loses the freshly loaded value or double-decrements it. It rewrites the count just before the 60th tick, where a design that does not clear the prescaler expires despite the keepalive. It also writes to unmapped addresses and drives an expiry with mixed enables, where a wrong decode or swapped enable shows up as a corrupted register or a pulse on the wrong output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ldCtl;
    logic ldCfg;
    logic ldLo;
    logic ldHi;
    logic dec;
    logic expire;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h71,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h72,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h73,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h74,
  parameter int TICKS_PER_MIN = 60,
  parameter bit WIDE          = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  input  logic              secMode,
  input  logic              countNonZero,
  input  logic              countIsOne,
  output wdt_strobe_t       strobe
);
  localparam int PRE_W = $clog2(TICKS_PER_MIN);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MIN - 1);

  logic [PRE_W-1:0] preQ;
  logic tickOk, preDone;

  assign tickOk  = tick && !wrEn && countNonZero;
  assign preDone = secMode || (preQ == PRE_LAST);

  always_comb begin
    strobe.ldCtl  = wrEn && (addr == CTL_ADDR);
    strobe.ldCfg  = wrEn && (addr == CFG_ADDR);
    strobe.ldLo   = wrEn && (addr == LO_ADDR);
    strobe.ldHi   = wrEn && (addr == HI_ADDR) && WIDE;
    strobe.dec    = tickOk && preDone;
    strobe.expire = tickOk && preDone && countIsOne;
  end

  // minute prescaler, cleared by any count reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preQ <= '0;
    else if (strobe.ldLo || strobe.ldHi) preQ <= '0;
    else if (tickOk) preQ <= preDone ? '0 : preQ + 1'b1;
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h71,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h72,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h73,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h74,
  parameter int SEC_BIT = 7,
  parameter int KBD_BIT = 6,
  parameter int EVT_BIT = 5,
  parameter int PWR_BIT = 4,
  parameter bit WIDE    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdt_strobe_t       strobe,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdData,
  output logic [15:0]       countOut,
  output logic [7:0]        cfgOut,
  output logic              countNonZero,
  output logic              countIsOne,
  output logic              secMode,
  output logic              kbdRst,
  output logic              pwrOkRst,
  output logic              toEvent
);
  logic [7:0] ctlQ, cfgQ, loQ, hiQ;
  logic [15:0] countDec;

  assign countOut     = {hiQ, loQ};
  assign countDec     = countOut - 16'd1;
  assign countNonZero = |countOut;
  assign countIsOne   = (countOut == 16'd1);
  assign secMode      = cfgQ[SEC_BIT];
  assign cfgOut       = cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0; cfgQ <= '0; loQ <= '0;
    end else begin
      if (strobe.ldCtl) ctlQ <= wrData;
      if (strobe.ldCfg) cfgQ <= wrData;
      if (strobe.ldLo) loQ <= wrData;
      else if (strobe.dec) loQ <= countDec[7:0];
    end
  end

  generate
    if (WIDE) begin : g_hi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hiQ <= '0;
        else if (strobe.ldHi) hiQ <= wrData;
        else if (strobe.dec) hiQ <= countDec[15:8];
      end
    end else begin : g_nohi
      assign hiQ = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdRst <= 1'b0; pwrOkRst <= 1'b0; toEvent <= 1'b0;
    end else begin
      kbdRst   <= strobe.expire && cfgQ[KBD_BIT];
      pwrOkRst <= strobe.expire && cfgQ[PWR_BIT];
      toEvent  <= strobe.expire && cfgQ[EVT_BIT];
    end
  end

  always_comb begin
    unique case (addr)
      CTL_ADDR: rdData = ctlQ;
      CFG_ADDR: rdData = cfgQ;
      LO_ADDR:  rdData = loQ;
      HI_ADDR:  rdData = hiQ;
      default:  rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/unit_watchdog.sv
module unit_watchdog
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_MIN = 60,
  parameter bit WIDE          = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       tick,
  output logic       running,
  output logic       kbdRst,
  output logic       pwrOkRst,
  output logic       toEvent
);
  wdt_strobe_t strobe;
  logic secMode, countNonZero, countIsOne;
  logic [15:0] countVal;
  logic [7:0]  cfgVal;

  assign running = countNonZero;

  wdt_ctrl #(.TICKS_PER_MIN(TICKS_PER_MIN), .WIDE(WIDE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .tick(tick),
    .secMode(secMode), .countNonZero(countNonZero), .countIsOne(countIsOne),
    .strobe(strobe)
  );

  wdt_datapath #(.WIDE(WIDE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .addr(addr),
    .rdData(rdData), .countOut(countVal), .cfgOut(cfgVal),
    .countNonZero(countNonZero), .countIsOne(countIsOne), .secMode(secMode),
    .kbdRst(kbdRst), .pwrOkRst(pwrOkRst), .toEvent(toEvent)
  );
endmodule

// File: rtl/wdt_sva.sv
module wdt_sva (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [7:0]  addr,
  input logic [7:0]  wrData,
  input logic        tick,
  input logic        running,
  input logic        kbdRst,
  input logic        pwrOkRst,
  input logic        toEvent,
  input logic [15:0] countVal,
  input logic [7:0]  cfgVal
);
  logic anyPulse;
  assign anyPulse = kbdRst || pwrOkRst || toEvent;

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !wrEn) |=> !running); // R3

  AST_SEC_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && cfgVal[7] && !wrEn) |=> countVal == $past(countVal) - 16'd1); // R4

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> $stable(countVal)); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |=> !anyPulse); // R6

  AST_PULSE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |-> !running); // R6

  AST_LO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h73) |=> countVal[7:0] == $past(wrData)); // R7
endmodule

bind unit_watchdog wdt_sva u_sva (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .tick(tick), .running(running), .kbdRst(kbdRst), .pwrOkRst(pwrOkRst),
  .toEvent(toEvent), .countVal(countVal), .cfgVal(cfgVal)
);

// File: tb/unit_watchdog_bench.sv
`timescale 1ns/1ps
module unit_watchdog_bench;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, tick = 1'b0;
  logic [7:0] addr = 8'h00, wrData = 8'h00;
  logic [7:0] rdData;
  logic running, kbdRst, pwrOkRst, toEvent;

  int checks = 0, errors = 0;
  logic [15:0] mCnt = '0;
  logic [7:0]  mCfg = '0, mCtl = '0;
  int mPre = 0;
  logic eKbd = 0, ePwr = 0, eEvt = 0;

  always #4 clk = ~clk;

  unit_watchdog u_unit_watchdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .running(running), .kbdRst(kbdRst),
    .pwrOkRst(pwrOkRst), .toEvent(toEvent)
  );

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h71: return mCtl;
      8'h72: return mCfg;
      8'h73: return mCnt[7:0];
      8'h74: return mCnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readCheck(input logic [7:0] a, input string req);
    wrEn = 1'b0; tick = 1'b0; addr = a;
    #1;
    check(req, {8'h00, rdData}, {8'h00, expRead(a)});
  endtask

  // one clock with reference-model update, outputs checked after the edge
  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d, input bit t);
    logic pulse;
    wrEn = w; addr = a; wrData = d; tick = t;
    @(posedge clk);
    pulse = 1'b0;
    if (w) begin
      case (a)
        8'h71: mCtl = d;
        8'h72: mCfg = d;
        8'h73: begin mCnt[7:0] = d; mPre = 0; end
        8'h74: begin mCnt[15:8] = d; mPre = 0; end
        default: ;
      endcase
    end else if (t && mCnt != 0) begin
      if (mCfg[7] || mPre == 59) begin
        mPre = 0;
        if (mCnt == 16'd1) pulse = 1'b1;
        mCnt = mCnt - 16'd1;
      end else mPre++;
    end
    eKbd = pulse && mCfg[6]; ePwr = pulse && mCfg[4]; eEvt = pulse && mCfg[5];
    #2;
    check("R3 running", {15'd0, running}, {15'd0, mCnt != 0});
    check("R6 kbdRst", {15'd0, kbdRst}, {15'd0, eKbd});
    check("R6 pwrOkRst", {15'd0, pwrOkRst}, {15'd0, ePwr});
    check("R6 toEvent", {15'd0, toEvent}, {15'd0, eEvt});
    #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #10;
    readCheck(8'h71, "R1 ctl"); readCheck(8'h72, "R1 cfg");
    readCheck(8'h73, "R1 lo");  readCheck(8'h74, "R1 hi");
    check("R1 outputs", {12'd0, running, kbdRst, pwrOkRst, toEvent}, 16'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R2: unmapped write ignored, mapped writes read back
    step(1, 8'h75, 8'hAA, 0); step(1, 8'h70, 8'h55, 0);
    step(1, 8'h71, 8'h3C, 0);
    for (int a = 8'h70; a <= 8'h75; a++) readCheck(a[7:0], "R2 readback");

    // R4: seconds unit, all enables
    step(1, 8'h72, 8'hF0, 0); step(1, 8'h73, 8'h03, 0);
    step(0, 8'h00, 8'h00, 1); step(0, 8'h00, 8'h00, 1);
    readCheck(8'h73, "R4 seconds decrement");
    step(0, 8'h00, 8'h00, 1);  // expiry: R6
    readCheck(8'h73, "R6 count zero after expiry");

    // R5: minutes unit, kbd + pwr only
    step(1, 8'h72, 8'h50, 0); step(1, 8'h73, 8'h02, 0);
    for (int i = 0; i < 59; i++) step(0, 8'h00, 8'h00, 1);
    readCheck(8'h73, "R5 no decrement before 60th tick");
    step(0, 8'h00, 8'h00, 1);
    readCheck(8'h73, "R5 decrement at 60th tick");
    for (int i = 0; i < 60; i++) step(0, 8'h00, 8'h00, 1);

    // R7: keepalive clears prescaler; write wins over tick
    step(1, 8'h73, 8'h01, 0);
    for (int i = 0; i < 59; i++) step(0, 8'h00, 8'h00, 1);
    step(1, 8'h73, 8'h01, 1);
    for (int i = 0; i < 59; i++) step(0, 8'h00, 8'h00, 1);
    readCheck(8'h73, "R7 keepalive held count");
    step(0, 8'h00, 8'h00, 1);
    // R3: writing zero stops
    step(1, 8'h72, 8'hE0, 0); step(1, 8'h74, 8'h01, 0); step(1, 8'h74, 8'h00, 0);
    step(1, 8'h73, 8'h00, 0);
    for (int i = 0; i < 5; i++) step(0, 8'h00, 8'h00, 1);
    readCheck(8'h73, "R3 stopped count");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a, d;
      bit w;
      w = ($urandom % 8) == 0;
      a = 8'h70 + 8'($urandom % 6);
      d = 8'($urandom);
      if (a == 8'h73) d = 8'($urandom % 5);
      if (a == 8'h74) d = (($urandom % 8) == 0) ? 8'h01 : 8'h00;
      if (a == 8'h72 && ($urandom % 3) != 0) d[7] = 1'b1;
      step(w, a, d, ($urandom % 2) == 1);
      if (i % 97 == 0) begin
        readCheck(8'h73, "R4 R5 R7 random lo");
        readCheck(8'h74, "R4 R5 R7 random hi");
        readCheck(8'h72, "R2 random cfg");
        readCheck(8'h71, "R2 random ctl");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule